// File: doc/BRIEF.md
# Dual Limit Current Test Classifier

This block decides the fate of one device under quiescent-current test. Per test pattern it receives a raw supply-current reading and a signed pattern-to-pattern difference reading. Each measure is judged against a lower and a higher confidence limit. Staying at or below the lower limit clears the device, and exceeding the higher limit condemns it. A device that lands between the two on the raw measure falls back to the difference measure. A device that lands between the two on both is handed to an external histogram-peak estimator, and the block then waits for that result.

Two coarse rejection limits, one for raw readings and one for difference magnitudes, let the tester stop a device as soon as a grossly bad sample is seen, without running the remaining patterns. All limits are held in a small register bank. A copy of the bank is latched at each device start, so a write made while a device is under test only affects the next device.

Top module: `iddq_classifier`

## Requirements
- R1: After reset, verdict is 2'b00, verdictValid is 0 and abortReq is 0.
- R2: Limit registers are written with cfgWe, cfgAddr and cfgData. The addresses are 0 raw-low, 1 raw-high, 2 diff-low, 3 diff-high, 4 histogram threshold, 5 raw-abort and 6 diff-abort. A device uses the register values present at its devStart pulse, so a write during a device does not change that device's result.
- R3: At the last pattern, if any raw sample of the device was strictly greater than raw-high, the verdict is 2'b01 (defective).
- R4: At the last pattern, if no raw sample was strictly greater than raw-low, the verdict is 2'b00 (good). A sample equal to a limit does not exceed it.
- R5: If the raw result is inconclusive, the difference measure decides. Any magnitude strictly above diff-high gives 2'b01. All magnitudes at or below diff-low give 2'b00.
- R6: If both measures are inconclusive, the end verdict is 2'b10 (awaiting histogram). A later histValid then gives 2'b01 when histPeak is strictly above the threshold, and 2'b00 otherwise. This final verdict is pulsed on verdictValid in the cycle after histValid.
- R7: A sample whose raw value exceeds raw-abort, or whose difference magnitude exceeds diff-abort, ends the device at once with verdict 2'b11 and a one-cycle abortReq pulse. Further samples are ignored until the next devStart.
- R8: After reset, both abort registers hold ABORT_DEFAULT, the code for 100 uA.
- R9: The difference input is two's complement, and its magnitude is what gets compared.
- R10: Every verdict appears one cycle after the sample or histValid that caused it, with verdictValid high for exactly one cycle. devStart clears the per-device maxima. histValid has no effect unless the block is awaiting a histogram result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Limit register write enable |
| cfgAddr | input | 3 | Limit register address |
| cfgData | input | DATA_W | Limit register write data |
| devStart | input | 1 | Start of a new device; latches limits and clears state |
| sampleValid | input | 1 | A current/difference sample is present |
| rawCurr | input | DATA_W | Raw quiescent current code |
| deltaCurr | input | DATA_W | Signed difference current code |
| lastPattern | input | 1 | Marks the final sample of the device |
| histValid | input | 1 | Histogram peak result is present |
| histPeak | input | DATA_W | Histogram peak current code |
| verdict | output | 2 | 00 good, 01 defective, 10 awaiting histogram, 11 aborted |
| verdictValid | output | 1 | One-cycle strobe when verdict is updated |
| abortReq | output | 1 | One-cycle early stop request |

## Verification
The bound checker watches the output protocol on every cycle. It checks that an abort always carries code 11 with a valid strobe, that strobes last one cycle, that every verdict has a sample or histogram strobe one cycle before it, that a histogram-driven verdict is always a final code, and that devStart is never followed by a verdict. Only the bench's scenarios can show the decision itself. That covers the strict-greater boundaries, the fall-through from raw to difference to histogram, magnitude handling of negative differences, the default abort level, and limits being latched at device start.

// File: rtl/iddq_classifier_pkg.sv
package iddq_classifier_pkg;

  typedef enum logic [1:0] {
    VD_GOOD   = 2'b00,
    VD_DEFECT = 2'b01,
    VD_WAIT   = 2'b10,
    VD_ABORT  = 2'b11
  } verdict_t;

  localparam int NUM_LIMITS = 7;
  localparam int LIM_RAW_LO  = 0;
  localparam int LIM_RAW_HI  = 1;
  localparam int LIM_DIF_LO  = 2;
  localparam int LIM_DIF_HI  = 3;
  localparam int LIM_HIST    = 4;
  localparam int LIM_RAW_AB  = 5;
  localparam int LIM_DIF_AB  = 6;

  // strobes from control to datapath
  typedef struct packed {
    logic clearDev;
    logic accumulate;
  } dpCtrl_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic rawOverLo;
    logic rawOverHi;
    logic difOverLo;
    logic difOverHi;
    logic abortHit;
    logic histFail;
  } dpStat_t;

endpackage

// File: rtl/iddq_classifier_dp.sv
module iddq_classifier_dp
  import iddq_classifier_pkg::*;
#(
  parameter int DATA_W        = 12,
  parameter int ABORT_DEFAULT = 1000,
  parameter int ADDR_W        = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtrl_t           ctrl,
  input  logic              cfgWe,
  input  logic [ADDR_W-1:0] cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic [DATA_W-1:0] rawCurr,
  input  logic [DATA_W-1:0] deltaCurr,
  input  logic [DATA_W-1:0] histPeak,
  output dpStat_t           stat
);

  localparam logic [DATA_W-1:0] ABORT_RST = DATA_W'(ABORT_DEFAULT);

  logic [DATA_W-1:0] cfgReg    [NUM_LIMITS];
  logic [DATA_W-1:0] activeLim [NUM_LIMITS];
  logic [DATA_W-1:0] rawMax, difMax;
  logic [DATA_W-1:0] deltaMag;
  logic [DATA_W-1:0] nextRawMax, nextDifMax;

  // programmable bank plus per-device latched copy
  for (genvar i = 0; i < NUM_LIMITS; i++) begin : g_limit
    localparam logic [DATA_W-1:0] RST_VAL =
      (i == LIM_RAW_AB || i == LIM_DIF_AB) ? ABORT_RST : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfgReg[i] <= RST_VAL;
      end else if (cfgWe && (cfgAddr == ADDR_W'(i))) begin
        cfgReg[i] <= cfgData;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        activeLim[i] <= RST_VAL;
      end else if (ctrl.clearDev) begin
        activeLim[i] <= cfgReg[i];
      end
    end
  end

  // two's complement magnitude; the most negative code maps to 2^(DATA_W-1)
  always_comb begin
    if (deltaCurr[DATA_W-1]) begin
      deltaMag = ~deltaCurr + DATA_W'(1);
    end else begin
      deltaMag = deltaCurr;
    end
  end

  always_comb begin
    nextRawMax = rawMax;
    nextDifMax = difMax;
    if (ctrl.accumulate) begin
      if (rawCurr > rawMax)  nextRawMax = rawCurr;
      if (deltaMag > difMax) nextDifMax = deltaMag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rawMax <= '0;
      difMax <= '0;
    end else if (ctrl.clearDev) begin
      rawMax <= '0;
      difMax <= '0;
    end else begin
      rawMax <= nextRawMax;
      difMax <= nextDifMax;
    end
  end

  always_comb begin
    stat.rawOverLo = nextRawMax > activeLim[LIM_RAW_LO];
    stat.rawOverHi = nextRawMax > activeLim[LIM_RAW_HI];
    stat.difOverLo = nextDifMax > activeLim[LIM_DIF_LO];
    stat.difOverHi = nextDifMax > activeLim[LIM_DIF_HI];
    stat.abortHit  = (rawCurr > activeLim[LIM_RAW_AB]) ||
                     (deltaMag > activeLim[LIM_DIF_AB]);
    stat.histFail  = histPeak > activeLim[LIM_HIST];
  end

endmodule

// File: rtl/iddq_classifier_ctrl.sv
module iddq_classifier_ctrl
  import iddq_classifier_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       devStart,
  input  logic       sampleValid,
  input  logic       lastPattern,
  input  logic       histValid,
  input  dpStat_t    stat,
  output dpCtrl_t    ctrl,
  output logic [1:0] verdict,
  output logic       verdictValid,
  output logic       abortReq
);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_HIST = 2'd2
  } state_t;

  state_t   state;
  verdict_t endCode;
  verdict_t histCode;

  assign ctrl.clearDev   = devStart;
  assign ctrl.accumulate = (state == ST_RUN) && sampleValid && !devStart;

  // escalation: raw limits, then difference limits, then histogram
  always_comb begin
    if (stat.rawOverHi) begin
      endCode = VD_DEFECT;
    end else if (!stat.rawOverLo) begin
      endCode = VD_GOOD;
    end else if (stat.difOverHi) begin
      endCode = VD_DEFECT;
    end else if (!stat.difOverLo) begin
      endCode = VD_GOOD;
    end else begin
      endCode = VD_WAIT;
    end
    histCode = stat.histFail ? VD_DEFECT : VD_GOOD;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      verdict      <= VD_GOOD;
      verdictValid <= 1'b0;
      abortReq     <= 1'b0;
    end else begin
      verdictValid <= 1'b0;
      abortReq     <= 1'b0;
      if (devStart) begin
        state <= ST_RUN;
      end else begin
        unique case (state)
          ST_RUN: begin
            if (sampleValid) begin
              if (stat.abortHit) begin
                verdict      <= VD_ABORT;
                verdictValid <= 1'b1;
                abortReq     <= 1'b1;
                state        <= ST_IDLE;
              end else if (lastPattern) begin
                verdict      <= endCode;
                verdictValid <= 1'b1;
                state        <= (endCode == VD_WAIT) ? ST_HIST : ST_IDLE;
              end
            end
          end
          ST_HIST: begin
            if (histValid) begin
              verdict      <= histCode;
              verdictValid <= 1'b1;
              state        <= ST_IDLE;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/iddq_classifier.sv
module iddq_classifier
  import iddq_classifier_pkg::*;
#(
  parameter int DATA_W        = 12,
  parameter int ABORT_DEFAULT = 1000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [2:0]        cfgAddr,
  input  logic [DATA_W-1:0] cfgData,
  input  logic              devStart,
  input  logic              sampleValid,
  input  logic [DATA_W-1:0] rawCurr,
  input  logic [DATA_W-1:0] deltaCurr,
  input  logic              lastPattern,
  input  logic              histValid,
  input  logic [DATA_W-1:0] histPeak,
  output logic [1:0]        verdict,
  output logic              verdictValid,
  output logic              abortReq
);

  dpCtrl_t dpCtrl;
  dpStat_t dpStat;

  iddq_classifier_dp #(
    .DATA_W       (DATA_W),
    .ABORT_DEFAULT(ABORT_DEFAULT),
    .ADDR_W       (3)
  ) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (dpCtrl),
    .cfgWe    (cfgWe),
    .cfgAddr  (cfgAddr),
    .cfgData  (cfgData),
    .rawCurr  (rawCurr),
    .deltaCurr(deltaCurr),
    .histPeak (histPeak),
    .stat     (dpStat)
  );

  iddq_classifier_ctrl u_ctrl (
    .clk         (clk),
    .rst_n       (rst_n),
    .devStart    (devStart),
    .sampleValid (sampleValid),
    .lastPattern (lastPattern),
    .histValid   (histValid),
    .stat        (dpStat),
    .ctrl        (dpCtrl),
    .verdict     (verdict),
    .verdictValid(verdictValid),
    .abortReq    (abortReq)
  );

endmodule

// File: rtl/iddq_classifier_chk.sv
module iddq_classifier_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       devStart,
  input logic       sampleValid,
  input logic       histValid,
  input logic [1:0] verdict,
  input logic       verdictValid,
  input logic       abortReq
);

  // R7: an abort request always carries the abort code with a valid strobe
  a_r7_abort_code: assert property (@(posedge clk) disable iff (!rst_n)
    abortReq |-> (verdictValid && verdict == 2'b11));

  // R7: abort request lasts one cycle
  a_r7_abort_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    abortReq |=> !abortReq);

  // R10: verdict strobe lasts one cycle
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    verdictValid |=> !verdictValid);

  // R10: every verdict has a sample or histogram strobe one cycle earlier
  a_r10_verdict_cause: assert property (@(posedge clk) disable iff (!rst_n)
    verdictValid |-> $past(sampleValid || histValid));

  // R6: a histogram-driven verdict is final (good or defective)
  a_r6_hist_final: assert property (@(posedge clk) disable iff (!rst_n)
    (verdictValid && !$past(sampleValid)) |-> (verdict inside {2'b00, 2'b01}));

  // R10: device start is never followed by a verdict
  a_r10_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    devStart |=> !verdictValid);

endmodule

bind iddq_classifier iddq_classifier_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .devStart    (devStart),
  .sampleValid (sampleValid),
  .histValid   (histValid),
  .verdict     (verdict),
  .verdictValid(verdictValid),
  .abortReq    (abortReq)
);

// File: tb/iddq_classifier_tb.sv
module iddq_classifier_tb;

  localparam int W = 12;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cfgWe = 1'b0;
  logic [2:0]   cfgAddr = '0;
  logic [W-1:0] cfgData = '0;
  logic         devStart = 1'b0;
  logic         sampleValid = 1'b0;
  logic [W-1:0] rawCurr = '0;
  logic [W-1:0] deltaCurr = '0;
  logic         lastPattern = 1'b0;
  logic         histValid = 1'b0;
  logic [W-1:0] histPeak = '0;
  logic [1:0]   verdict;
  logic         verdictValid;
  logic         abortReq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  iddq_classifier #(.DATA_W(W), .ABORT_DEFAULT(1000)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgAddr(cfgAddr),
    .cfgData(cfgData), .devStart(devStart), .sampleValid(sampleValid),
    .rawCurr(rawCurr), .deltaCurr(deltaCurr), .lastPattern(lastPattern),
    .histValid(histValid), .histPeak(histPeak), .verdict(verdict),
    .verdictValid(verdictValid), .abortReq(abortReq)
  );

  // table: four samples per device, histogram peak, end and final verdicts
  localparam int NV = 7;
  localparam int RAWV [NV][4] = '{
    '{50, 60, 100, 70}, '{50, 201, 60, 70}, '{50, 200, 60, 70},
    '{150, 120, 110, 105}, '{150, 120, 110, 105},
    '{150, 120, 110, 105}, '{150, 120, 110, 105}};
  localparam int DIFV [NV][4] = '{
    '{5, -10, 20, 0}, '{5, 0, 0, 0}, '{5, 41, -3, 0},
    '{10, -20, 20, 5}, '{10, -41, 0, 0},
    '{25, -30, 0, 0}, '{25, -30, 0, 0}};
  localparam int HPV  [NV] = '{0, 0, 0, 0, 0, 31, 30};
  localparam int ENDV [NV] = '{0, 1, 1, 0, 1, 2, 2};
  localparam int FINV [NV] = '{0, 1, 1, 0, 1, 1, 0};
  localparam string TAGV [NV] = '{"R4", "R3", "R5", "R5", "R9", "R6", "R6"};

  task automatic chk(string req, logic [1:0] actV, logic actS, logic actA,
                     logic [1:0] expV, logic expS, logic expA);
    nChecks++;
    if (actV !== expV || actS !== expS || actA !== expA) begin
      nFails++;
      $display("FAIL %s: verdict=%b valid=%b abort=%b expected verdict=%b valid=%b abort=%b",
               req, actV, actS, actA, expV, expS, expA);
    end
  endtask

  task automatic writeCfg(int a, int d);
    @(negedge clk);
    cfgWe = 1'b1; cfgAddr = 3'(a); cfgData = W'(d);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic startDev();
    @(negedge clk);
    devStart = 1'b1;
    @(negedge clk);
    devStart = 1'b0;
  endtask

  // drives one sample; returns at the negedge after the capturing edge
  task automatic sample(int r, int d, bit last);
    sampleValid = 1'b1; rawCurr = W'(r); deltaCurr = W'(d); lastPattern = last;
    @(negedge clk);
    sampleValid = 1'b0; lastPattern = 1'b0;
  endtask

  task automatic histo(int p);
    histValid = 1'b1; histPeak = W'(p);
    @(negedge clk);
    histValid = 1'b0;
  endtask

  initial begin : watchdog
    #2000000;
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk("R1 reset", verdict, verdictValid, abortReq, 2'b00, 1'b0, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", verdict, verdictValid, abortReq, 2'b00, 1'b0, 1'b0);

    // R8: abort limits untouched, default 1000 applies
    writeCfg(0, 100); writeCfg(1, 200); writeCfg(2, 20);
    writeCfg(3, 40);  writeCfg(4, 30);

    // R2 and table walk
    for (int v = 0; v < NV; v++) begin
      startDev();
      for (int s = 0; s < 3; s++) begin
        sample(RAWV[v][s], DIFV[v][s], 1'b0);
        chk(TAGV[v], verdict, verdictValid, abortReq, verdict, 1'b0, 1'b0);
      end
      sample(RAWV[v][3], DIFV[v][3], 1'b1);
      chk(TAGV[v], verdict, verdictValid, abortReq, 2'(ENDV[v]), 1'b1, 1'b0);
      if (ENDV[v] == 2) begin
        @(negedge clk);
        chk("R6 wait holds", verdict, verdictValid, abortReq, 2'b10, 1'b0, 1'b0);
        histo(HPV[v]);
        chk(TAGV[v], verdict, verdictValid, abortReq, 2'(FINV[v]), 1'b1, 1'b0);
      end
      @(negedge clk);
    end

    // R8: raw exactly at default abort does not abort; ends defective
    startDev();
    sample(1000, 0, 1'b0);
    chk("R8 at limit", verdict, verdictValid, abortReq, verdict, 1'b0, 1'b0);
    sample(50, 0, 1'b1);
    chk("R8 end", verdict, verdictValid, abortReq, 2'b01, 1'b1, 1'b0);

    // R7/R8: raw above default abort aborts at once, later samples ignored
    startDev();
    sample(50, 0, 1'b0);
    sample(1001, 0, 1'b0);
    chk("R7 raw abort", verdict, verdictValid, abortReq, 2'b11, 1'b1, 1'b1);
    chk("R7 abort pulse", verdict, verdictValid, abortReq, 2'b11, 1'b1, 1'b1);
    sample(50, 0, 1'b0);
    chk("R7 abort one cycle", verdict, verdictValid, abortReq, 2'b11, 1'b0, 1'b0);
    sample(50, 0, 1'b1);
    chk("R7 ignored after abort", verdict, verdictValid, abortReq, 2'b11, 1'b0, 1'b0);

    // R9/R7: negative difference beyond abort magnitude
    startDev();
    sample(50, -1001, 1'b0);
    chk("R9 neg diff abort", verdict, verdictValid, abortReq, 2'b11, 1'b1, 1'b1);

    // R10: histogram strobe ignored when not awaiting
    @(negedge clk);
    histo(0);
    chk("R10 stray hist", verdict, verdictValid, abortReq, 2'b11, 1'b0, 1'b0);

    // R2: write during a device does not affect it
    startDev();
    sample(300, 0, 1'b0);
    writeCfg(1, 500);
    writeCfg(5, 250);
    sample(120, 0, 1'b1);
    chk("R2 latched limits", verdict, verdictValid, abortReq, 2'b01, 1'b1, 1'b0);
    // next device sees new raw-high 500 and raw-abort 250
    startDev();
    sample(240, 0, 1'b1);
    chk("R2 new high", verdict, verdictValid, abortReq, 2'b00, 1'b1, 1'b0);
    startDev();
    sample(251, 0, 1'b0);
    chk("R2 new abort", verdict, verdictValid, abortReq, 2'b11, 1'b1, 1'b1);

    // R10: devStart clears maxima (previous 251 must not carry over)
    startDev();
    sample(60, 0, 1'b1);
    chk("R10 cleared max", verdict, verdictValid, abortReq, 2'b00, 1'b1, 1'b0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule